// File: doc/BRIEF.md
# BLDC Drive Supervisor and Tachometer

This block sits between a commutation sequencer and a three-phase gate driver. It decides, every clock, whether the six gate outputs may follow the commutation pattern, must short the motor through the low-side switches, or must all be off. The inputs are an active-low start request, an active-high brake request, a direction bit, three hall sensor bits and four fault flags: undervoltage on the main supply, on the charge pump and on the hall bias, and overtemperature.

The hall bits pass a two-stage synchronizer and then a digital filter. The filter takes a new code only after it has seen the code on N consecutive clocks. The filtered code is checked for the two impossible codes, all zeros and all ones. Each change of the filtered code toggles a tachometer output. Faults do not latch. Once every condition has gone away, the gate outputs follow the requests again. Start, brake, direction and the fault flags are synchronized by two flops. The gate outputs come from registers, so a change on one of these inputs reaches the outputs on the third rising clock edge.

Top module: `bldc_supervisor`

## Requirements
- R1: While reset is asserted, and right after it, every gate output is 0, fault_o is 1, hall_o is 3'b000 and tach_o is 0.
- R2: When start_n_i is 1, all six gate outputs are 0 whatever brake_i and the commutation inputs are.
- R3: When start_n_i is 0, brake_i is 1 and there is no fault, gate_lo_o is 3'b111 and gate_hi_o is 3'b000.
- R4: brake_i has no effect while start_n_i is 1. The gate outputs stay all 0.
- R5: When start_n_i is 0, brake_i is 0 and there is no fault, each phase copies cmt_hi_i and cmt_lo_i, bit k driving phase k. A phase with both of its requests set drives neither switch.
- R6: A filtered hall code of 3'b000 or 3'b111 sets fault_o and forces all gate outputs to 0.
- R7: Any of uv_supply_i, uv_pump_i, uv_hbias_i and overtemp_i at 1 sets fault_o and forces all gate outputs to 0, whatever the start and brake inputs are.
- R8: Faults are not latched. Once all fault conditions clear, fault_o returns to 0 and the gate outputs follow the requests again.
- R9: fwd_o follows dir_i, with 1 meaning forward and 0 meaning reverse.
- R10: tach_o inverts exactly once for each change of the filtered hall code hall_o and holds otherwise.
- R11: A hall code reaches hall_o only after it has been seen on HALL_STABLE (default 4) consecutive synchronized samples. A code that lasts HALL_STABLE-1 clocks is ignored.
- R12: For no phase are gate_hi_o and gate_lo_o both 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_n_i | input | 1 | Start request, 0 = run allowed |
| brake_i | input | 1 | Brake request, 1 = all low sides on |
| dir_i | input | 1 | Direction, 1 = forward |
| hall_i | input | 3 | Raw hall sensor bits |
| uv_supply_i | input | 1 | Supply undervoltage flag |
| uv_pump_i | input | 1 | Charge pump undervoltage flag |
| uv_hbias_i | input | 1 | Hall bias undervoltage flag |
| overtemp_i | input | 1 | Overtemperature flag |
| cmt_hi_i | input | 3 | Commutation high-side requests, one per phase |
| cmt_lo_i | input | 3 | Commutation low-side requests, one per phase |
| gate_hi_o | output | 3 | Registered high-side gate enables |
| gate_lo_o | output | 3 | Registered low-side gate enables |
| fault_o | output | 1 | Any fault active |
| fwd_o | output | 1 | Synchronized direction to the commutator |
| hall_o | output | 3 | Filtered hall code |
| tach_o | output | 1 | Tachometer, toggles per hall change |

## Verification
The assertions check, on every cycle, that no phase has both switches on, that a fault never leaves a gate on, that an invalid filtered hall code is followed by a fault, and that tach_o moves exactly when hall_o moves. They also check the three-edge path from the start, brake and direction pins to the outputs. Only the bench scenarios show that a faulted drive recovers on its own once the flags drop, that a hall glitch one clock shorter than the filter window leaves no trace, and that a glitch of exactly the window length is taken and then taken back.

// File: rtl/bldc_sup_pkg.sv
package bldc_sup_pkg;

    localparam int PHASES = 3;

    typedef enum logic [1:0] {
        DRV_OFF   = 2'd0,
        DRV_RUN   = 2'd1,
        DRV_BRAKE = 2'd2
    } drv_mode_e;

    typedef struct packed {
        logic [PHASES-1:0] hi;
        logic [PHASES-1:0] lo;
        logic              fault;
        logic              fwd;
    } drv_state_t;

    function automatic logic hall_invalid(input logic [PHASES-1:0] code);
        return (code == '0) || (code == '1);
    endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0,
    parameter int          STAGES  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hall_filter.sv
module hall_filter #(
    parameter int W      = 3,
    parameter int STABLE = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] code_o,
    output logic         tach_o
);
    localparam int CW = $clog2(STABLE + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

    typedef struct packed {
        logic [W-1:0]  cand;
        logic [CW-1:0] cnt;
        logic [W-1:0]  code;
        logic          tach;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw_i != st_q.cand) begin
            st_d.cand = raw_i;
            st_d.cnt  = CW'(1);
        end else if (st_q.cnt < LAST) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end else begin
            if (st_q.cand != st_q.code) begin
                st_d.code = st_q.cand;
                st_d.tach = ~st_q.tach;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;
    assign tach_o = st_q.tach;
endmodule

// File: rtl/drive_ctrl.sv
module drive_ctrl
    import bldc_sup_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n_s,
    input  logic              brake_s,
    input  logic              dir_s,
    input  logic [3:0]        flags_s,
    input  logic [PHASES-1:0] hall_code,
    input  logic [PHASES-1:0] cmt_hi,
    input  logic [PHASES-1:0] cmt_lo,
    output drv_state_t        state_o
);
    drv_state_t st_d, st_q;
    drv_mode_e  mode;
    logic       fault_now;
    logic [PHASES-1:0] run_hi, run_lo;

    genvar p;
    generate
        for (p = 0; p < PHASES; p++) begin : g_phase
            assign run_hi[p] = cmt_hi[p] & ~cmt_lo[p];
            assign run_lo[p] = cmt_lo[p] & ~cmt_hi[p];
        end
    endgenerate

    always_comb begin
        fault_now = (|flags_s) | hall_invalid(hall_code);
        if (fault_now || start_n_s) mode = DRV_OFF;
        else if (brake_s)           mode = DRV_BRAKE;
        else                        mode = DRV_RUN;

        st_d       = st_q;
        st_d.fault = fault_now;
        st_d.fwd   = dir_s;
        unique case (mode)
            DRV_RUN: begin
                st_d.hi = run_hi;
                st_d.lo = run_lo;
            end
            DRV_BRAKE: begin
                st_d.hi = '0;
                st_d.lo = '1;
            end
            default: begin
                st_d.hi = '0;
                st_d.lo = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{hi: '0, lo: '0, fault: 1'b1, fwd: 1'b0};
        else        st_q <= st_d;
    end

    assign state_o = st_q;
endmodule

// File: rtl/bldc_supervisor.sv
module bldc_supervisor
    import bldc_sup_pkg::*;
#(
    parameter int HALL_STABLE = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_n_i,
    input  logic       brake_i,
    input  logic       dir_i,
    input  logic [2:0] hall_i,
    input  logic       uv_supply_i,
    input  logic       uv_pump_i,
    input  logic       uv_hbias_i,
    input  logic       overtemp_i,
    input  logic [2:0] cmt_hi_i,
    input  logic [2:0] cmt_lo_i,
    output logic [2:0] gate_hi_o,
    output logic [2:0] gate_lo_o,
    output logic       fault_o,
    output logic       fwd_o,
    output logic [2:0] hall_o,
    output logic       tach_o
);
    localparam int SW = 7 + PHASES;
    localparam logic [SW-1:0] SYNC_RST = SW'(1);

    logic [SW-1:0] raw_vec, sync_vec;
    logic [PHASES-1:0] hall_code;
    drv_state_t        drv;

    assign raw_vec = {hall_i, overtemp_i, uv_hbias_i, uv_pump_i, uv_supply_i,
                      dir_i, brake_i, start_n_i};

    sup_sync #(.W(SW), .RST_VAL(SYNC_RST), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_vec),
        .q_o   (sync_vec)
    );

    hall_filter #(.W(PHASES), .STABLE(HALL_STABLE)) u_hall (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (sync_vec[SW-1 -: PHASES]),
        .code_o (hall_code),
        .tach_o (tach_o)
    );

    drive_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_n_s (sync_vec[0]),
        .brake_s   (sync_vec[1]),
        .dir_s     (sync_vec[2]),
        .flags_s   (sync_vec[6:3]),
        .hall_code (hall_code),
        .cmt_hi    (cmt_hi_i),
        .cmt_lo    (cmt_lo_i),
        .state_o   (drv)
    );

    assign gate_hi_o = drv.hi;
    assign gate_lo_o = drv.lo;
    assign fault_o   = drv.fault;
    assign fwd_o     = drv.fwd;
    assign hall_o    = hall_code;
endmodule

// File: rtl/bldc_supervisor_chk.sv
module bldc_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_n_i,
    input logic       brake_i,
    input logic       dir_i,
    input logic [2:0] hall_o,
    input logic [2:0] gate_hi_o,
    input logic [2:0] gate_lo_o,
    input logic       fault_o,
    input logic       fwd_o,
    input logic       tach_o
);
    logic [1:0] age_q;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
    assign warm = (age_q == 2'd3);

    a_r12_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi_o & gate_lo_o) == 3'b000);

    a_r7_fault_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000));

    a_r6_bad_hall_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (hall_o == 3'b000 || hall_o == 3'b111) |=> fault_o);

    a_r10_tach_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hall_o) |-> !$stable(tach_o));

    a_r10_tach_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(hall_o) |-> $stable(tach_o));

    a_r2_stop_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(start_n_i, 3)) |-> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000));

    a_r3_brake_low_sides: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(start_n_i, 3) && $past(brake_i, 3) && !fault_o)
        |-> (gate_lo_o == 3'b111 && gate_hi_o == 3'b000));

    a_r9_direction: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (fwd_o == $past(dir_i, 3)));
endmodule

bind bldc_supervisor bldc_supervisor_chk u_chk (.*);

// File: tb/test_bldc_supervisor.sv
module test_bldc_supervisor;
    localparam int N = 4;
    localparam int SETTLE = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_n_i = 1'b1, brake_i = 1'b0, dir_i = 1'b0;
    logic [2:0] hall_i = 3'b001;
    logic       uv_supply_i = 1'b0, uv_pump_i = 1'b0, uv_hbias_i = 1'b0, overtemp_i = 1'b0;
    logic [2:0] cmt_hi_i = '0, cmt_lo_i = '0;
    logic [2:0] gate_hi_o, gate_lo_o, hall_o;
    logic       fault_o, fwd_o, tach_o;

    int checks = 0, fails = 0;
    int tach_edges = 0;
    logic tach_prev = 1'b0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    bldc_supervisor #(.HALL_STABLE(N)) i_bldc_supervisor (.*);

    always @(negedge clk) begin
        if (rst_n && tach_o != tach_prev) tach_edges++;
        tach_prev <= tach_o;
    end

    function automatic logic exp_fault(input logic [2:0] h, input logic [3:0] f);
        return (|f) || h == 3'b000 || h == 3'b111;
    endfunction

    function automatic logic [5:0] exp_gates(input logic sn, input logic br, input logic flt,
                                             input logic [2:0] ch, input logic [2:0] cl);
        if (flt || sn) return 6'b0;
        if (br)        return {3'b000, 3'b111};
        return {ch & ~cl, cl & ~ch};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        logic [3:0] f;
        logic       flt;
        logic [5:0] g;
        f   = {overtemp_i, uv_hbias_i, uv_pump_i, uv_supply_i};
        flt = exp_fault(hall_i, f);
        g   = exp_gates(start_n_i, brake_i, flt, cmt_hi_i, cmt_lo_i);
        check({req, " gates"}, {26'd0, gate_hi_o, gate_lo_o}, {26'd0, g});
        check({req, " fault"}, {31'd0, fault_o}, {31'd0, flt});
        check({req, " R9 fwd"}, {31'd0, fwd_o}, {31'd0, dir_i});
        check({req, " R11 hall"}, {29'd0, hall_o}, {29'd0, hall_i});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int base;
        logic [2:0] prev_hall;
        void'($urandom(32'd20240611));

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 reset gates", {29'd0, gate_hi_o | gate_lo_o}, 32'd0);
        check("R1 reset fault", {31'd0, fault_o}, 32'd1);
        check("R1 reset hall", {29'd0, hall_o}, 32'd0);
        check("R1 reset tach", {31'd0, tach_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release gates", {29'd0, gate_hi_o | gate_lo_o}, 32'd0);

        // R5 run with valid hall, including a phase with both requests
        start_n_i = 1'b0; dir_i = 1'b1; hall_i = 3'b101;
        cmt_hi_i = 3'b011; cmt_lo_i = 3'b110;
        settle();
        check_all("R5 run overlap");
        // R3 brake
        brake_i = 1'b1;
        settle();
        check_all("R3 brake");
        // R4 brake ignored while stopped
        start_n_i = 1'b1;
        settle();
        check_all("R4 brake while stopped");
        check("R2 stop", {29'd0, gate_hi_o | gate_lo_o}, 32'd0);
        // R6 invalid hall, R8 recovery
        start_n_i = 1'b0; brake_i = 1'b0; hall_i = 3'b111;
        settle();
        check_all("R6 hall 111");
        hall_i = 3'b000;
        settle();
        check_all("R6 hall 000");
        hall_i = 3'b010;
        settle();
        check_all("R8 hall recovered");
        // R7 flags, R8 recovery
        uv_pump_i = 1'b1; brake_i = 1'b1;
        settle();
        check_all("R7 pump uv");
        uv_pump_i = 1'b0; overtemp_i = 1'b1;
        settle();
        check_all("R7 overtemp");
        overtemp_i = 1'b0;
        settle();
        check_all("R8 flags cleared");
        check("R8 low sides back", {29'd0, gate_lo_o}, 32'd7);

        // R11 glitch one shorter than window is ignored
        hall_i = 3'b011; settle();
        base = tach_edges;
        hall_i = 3'b110;
        repeat (N - 1) @(negedge clk);
        hall_i = 3'b011;
        settle();
        check("R11 short glitch tach", base, tach_edges);
        check("R11 short glitch hall", {29'd0, hall_o}, 32'd3);
        // R11/R10 glitch of exactly the window is taken then undone
        base = tach_edges;
        hall_i = 3'b110;
        repeat (N) @(negedge clk);
        hall_i = 3'b011;
        settle();
        check("R10 window glitch two toggles", tach_edges - base, 32'd2);

        // random vectors
        prev_hall = hall_o;
        for (int v = 0; v < 300; v++) begin
            logic [2:0] h;
            h = 3'($urandom_range(0, 7));
            start_n_i   = ($urandom_range(0, 3) == 0);
            brake_i     = ($urandom_range(0, 2) == 0);
            dir_i       = 1'($urandom_range(0, 1));
            uv_supply_i = ($urandom_range(0, 9) == 0);
            uv_pump_i   = ($urandom_range(0, 9) == 0);
            uv_hbias_i  = ($urandom_range(0, 9) == 0);
            overtemp_i  = ($urandom_range(0, 9) == 0);
            cmt_hi_i    = 3'($urandom_range(0, 7));
            cmt_lo_i    = 3'($urandom_range(0, 7));
            hall_i      = h;
            base = tach_edges;
            settle();
            check_all("R2 R3 R5 R6 R7 random");
            check("R10 random tach", tach_edges - base, (h != prev_hall) ? 32'd1 : 32'd0);
            check("R12 random pair", {29'd0, gate_hi_o & gate_lo_o}, 32'd0);
            prev_hall = h;
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule